// File: doc/BRIEF.md
# Banked General Register File

This block holds the eight 16-bit general registers of a minicomputer-style processor core. Registers 0 to 5 exist twice, and one status-word bit chooses which set is in use. Register 6 is the stack pointer. It has one copy for each of four processor modes. The current-mode field of the status word normally picks the copy, and the previous-mode field picks it when an access asks for the previous mode. Register 7 is the program counter, and there is only one of it.

The core sees one combinational read port and one write port. Each port carries a register number and a previous-mode flag. A byte-mode read clears the upper half of the result. A write can ask for its low byte to be sign-extended, as a byte move into a register needs. The block also builds the status word for trap entry: it takes the status word loaded from the trap vector and puts the old current-mode field into its previous-mode field. Instruction decode and the memory bus sit outside the block.

Top module: `rf_banked`

## Requirements
- R1: For register numbers 0 to 5, status bit 11 selects the set: 0 selects the first set and 1 selects the second. Both reads and writes use the selected set, and the other set is left unchanged.
- R2: For register number 6 with the previous-mode flag clear, the access uses the stack-pointer copy indexed by status bits 15:14, which hold a value 0 to 3.
- R3: For register number 6 with the previous-mode flag set, the access uses the copy indexed by status bits 13:12.
- R4: Register number 7 is a single program counter. A value written to it reads back the same for every status word and every previous-mode flag.
- R5: When `rd_byte` is 1, `rd_data[7:0]` is the low byte of the selected register and `rd_data[15:8]` is zero.
- R6: `trap_psw_out` equals `trap_psw_in`, except that bits 13:12 of the output are taken from bits 15:14 of `psw`.
- R7: When `wr_sext` is 1, the register is loaded with `wr_data[7:0]` sign-extended to 16 bits, so bit 7 is copied into bits 15:8.
- R8: While `rst_n` is low at a clock edge, every low register in both sets, all four stack-pointer copies and the program counter clear to zero.
- R9: A read of the register being written in the same cycle returns the old value. The new value is visible from the cycle after the clock edge.
- R10: The previous-mode flag has no effect for register numbers other than 6, on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| psw | input | 16 | Current status word: bit 11 set select, 15:14 current mode, 13:12 previous mode |
| rd_num | input | 3 | Read register number |
| rd_prev | input | 1 | Read uses the previous-mode stack pointer |
| rd_byte | input | 1 | Byte-mode read: clear the upper 8 bits |
| rd_data | output | 16 | Read result (combinational) |
| wr_en | input | 1 | Write enable |
| wr_num | input | 3 | Write register number |
| wr_prev | input | 1 | Write uses the previous-mode stack pointer |
| wr_sext | input | 1 | Sign-extend the low byte of the write data |
| wr_data | input | 16 | Write data |
| trap_psw_in | input | 16 | Status word loaded from the trap vector |
| trap_psw_out | output | 16 | Trap-entry status word with the previous-mode field filled in |

## Verification
The read data and the trap status word are combinational, so they are due in the same cycle as their inputs. A write is due one clock edge after it is presented. The bench drives its inputs on the falling edge, waits a short delay, and then compares `rd_data` and `trap_psw_out` against its own model. It updates that model only after the following rising edge, so a read in the same cycle as a write is still compared against the old value, as R9 requires.

// File: rtl/rf_pkg.sv
// Package: shared constants and helpers for the banked register file.
// Assumes a 16-bit status word with fixed field positions.
package rf_pkg;
    localparam int PSW_SET_BIT  = 11;  // low-register set select
    localparam int PSW_CUR_LSB  = 14;  // current-mode field 15:14
    localparam int PSW_PRV_LSB  = 12;  // previous-mode field 13:12
    localparam int MODE_W       = 2;
    localparam int REGNUM_W     = 3;
    localparam logic [REGNUM_W-1:0] SP_NUM = 3'd6;
    localparam logic [REGNUM_W-1:0] PC_NUM = 3'd7;

    // Sign-extend the low byte of a 16-bit word.
    function automatic logic [15:0] sext_byte(input logic [15:0] v);
        return {{8{v[7]}}, v[7:0]};
    endfunction
endpackage

// File: rtl/rf_low_bank.sv
// Module: rf_low_bank
// Holds NUM_SETS sets of NUM_LOW registers. One write and one read per cycle.
// Assumes the caller qualifies wr_en with the register-number decode.
module rf_low_bank #(
    parameter int DATA_W   = 16,
    parameter int NUM_LOW  = 6,
    parameter int NUM_SETS = 2,
    localparam int IDX_W   = $clog2(NUM_LOW),
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRIES = NUM_SETS * NUM_LOW;

    logic [DATA_W-1:0] q [ENTRIES];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar i = 0; i < NUM_LOW; i++) begin : g_reg
            // Storage element: clear on reset, load when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[s*NUM_LOW+i] <= '0;
                else if (wr_en && wr_set == SET_W'(s) && wr_idx == IDX_W'(i))
                    q[s*NUM_LOW+i] <= wr_data;
            end
        end
    end

    // Read mux over the flattened storage.
    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < NUM_LOW && int'(rd_set) < NUM_SETS)
            rd_data = q[int'(rd_set)*NUM_LOW + int'(rd_idx)];
    end
endmodule

// File: rtl/rf_sp_bank.sv
// Module: rf_sp_bank
// One stack-pointer copy per processor mode, indexed by a mode number.
// Assumes the caller resolves the current/previous mode before indexing.
module rf_sp_bank #(
    parameter int DATA_W = 16,
    parameter int MODE_W = 2,
    localparam int COPIES = 1 << MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MODE_W-1:0] rd_mode,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sp_q [COPIES];

    for (genvar m = 0; m < COPIES; m++) begin : g_copy
        // Per-mode copy: clear on reset, load when its mode is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sp_q[m] <= '0;
            else if (wr_en && wr_mode == MODE_W'(m))
                sp_q[m] <= wr_data;
        end
    end

    // Select the copy for the read mode.
    assign rd_data = sp_q[rd_mode];
endmodule

// File: rtl/rf_trap_merge.sv
// Module: rf_trap_merge
// Forms the trap-entry status word: the old current mode becomes the
// previous mode, and every other bit comes from the vector's status word.
// Assumes a 16-bit status word with the package field positions.
module rf_trap_merge
    import rf_pkg::*;
(
    input  logic [15:0] old_psw,
    input  logic [15:0] vec_psw,
    output logic [15:0] new_psw
);
    // Replace the previous-mode field with the old current mode.
    always_comb begin
        new_psw = vec_psw;
        new_psw[PSW_PRV_LSB +: MODE_W] = old_psw[PSW_CUR_LSB +: MODE_W];
    end
endmodule

// File: rtl/rf_banked.sv
// Module: rf_banked (top)
// Eight-entry general register file: banked low registers, a per-mode stack
// pointer and a single program counter. Reads are combinational; writes
// land on the clock edge. Assumes DATA_W is 16 to match the status word.
module rf_banked
    import rf_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_LOW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         psw,
    input  logic [REGNUM_W-1:0] rd_num,
    input  logic                rd_prev,
    input  logic                rd_byte,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [REGNUM_W-1:0] wr_num,
    input  logic                wr_prev,
    input  logic                wr_sext,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [15:0]         trap_psw_in,
    output logic [15:0]         trap_psw_out
);
    localparam int IDX_W = $clog2(NUM_LOW);

    logic              set_sel;
    logic [MODE_W-1:0] cur_mode, prv_mode, rd_mode, wr_mode;
    logic [DATA_W-1:0] wval, low_rd, sp_rd, raw_rd;
    logic              wr_low, wr_sp, wr_pc;
    logic [DATA_W-1:0] pc_q;

    // Status-word field extraction.
    assign set_sel  = psw[PSW_SET_BIT];
    assign cur_mode = psw[PSW_CUR_LSB +: MODE_W];
    assign prv_mode = psw[PSW_PRV_LSB +: MODE_W];

    // Mode index for the stack pointer; the flag only matters for register 6.
    assign rd_mode = rd_prev ? prv_mode : cur_mode;
    assign wr_mode = wr_prev ? prv_mode : cur_mode;

    // Write value: optional byte sign extension.
    assign wval = wr_sext ? {{(DATA_W-8){wr_data[7]}}, wr_data[7:0]} : wr_data;

    // Write target decode.
    assign wr_low = wr_en && (int'(wr_num) < NUM_LOW);
    assign wr_sp  = wr_en && (wr_num == SP_NUM);
    assign wr_pc  = wr_en && (wr_num == PC_NUM);

    rf_low_bank #(.DATA_W(DATA_W), .NUM_LOW(NUM_LOW), .NUM_SETS(2)) u_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_low),
        .wr_set  (set_sel),
        .wr_idx  (wr_num[IDX_W-1:0]),
        .wr_data (wval),
        .rd_set  (set_sel),
        .rd_idx  (rd_num[IDX_W-1:0]),
        .rd_data (low_rd)
    );

    rf_sp_bank #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_sp),
        .wr_mode (wr_mode),
        .wr_data (wval),
        .rd_mode (rd_mode),
        .rd_data (sp_rd)
    );

    // Program counter: one copy shared by every mode and set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (wr_pc)
            pc_q <= wval;
    end

    // Read source select by register number.
    always_comb begin
        if (rd_num == PC_NUM)      raw_rd = pc_q;
        else if (rd_num == SP_NUM) raw_rd = sp_rd;
        else                       raw_rd = low_rd;
    end

    // Byte-mode read mask.
    assign rd_data = rd_byte ? {{(DATA_W-8){1'b0}}, raw_rd[7:0]} : raw_rd;

    rf_trap_merge u_trap (
        .old_psw (psw),
        .vec_psw (trap_psw_in),
        .new_psw (trap_psw_out)
    );
endmodule

// File: rtl/rf_banked_chk.sv
// Module: rf_banked_chk
// Port-level properties for rf_banked, attached by bind.
module rf_banked_chk #(
    parameter int DATA_W  = 16,
    parameter int NUM_LOW = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       psw,
    input logic [2:0]        rd_num,
    input logic              rd_prev,
    input logic              rd_byte,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [2:0]        wr_num,
    input logic              wr_prev,
    input logic              wr_sext,
    input logic [DATA_W-1:0] wr_data,
    input logic [15:0]       trap_psw_in,
    input logic [15:0]       trap_psw_out
);
    // R5: byte reads never carry upper bits.
    p_byte_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_byte |-> rd_data[DATA_W-1:8] == '0);

    // R6: trap word mode fields.
    p_trap_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_psw_out[13:12] == psw[15:14]) &&
        (trap_psw_out[15:14] == trap_psw_in[15:14]) &&
        (trap_psw_out[11:0] == trap_psw_in[11:0]));

    // R4: program counter reads back its last full-word write.
    p_pc_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_num == 3'd7 && !wr_sext) |=>
        (rd_num != 3'd7 || rd_byte || rd_data == $past(wr_data)));

    // R7: a sign-extending write reads back extended in the next cycle.
    p_sext_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sext) |=>
        (rd_num != $past(wr_num) || rd_prev != $past(wr_prev) ||
         psw != $past(psw) || rd_byte ||
         rd_data == {{(DATA_W-8){$past(wr_data[7])}}, $past(wr_data[7:0])}));

    // R8: after a reset edge every register reads zero.
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0);
endmodule

bind rf_banked rf_banked_chk #(.DATA_W(DATA_W), .NUM_LOW(NUM_LOW)) u_chk (.*);

// File: tb/rf_banked_test.sv
module rf_banked_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] psw = '0;
    logic [2:0]  rd_num = '0;
    logic        rd_prev = 1'b0, rd_byte = 1'b0;
    logic [15:0] rd_data;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_num = '0;
    logic        wr_prev = 1'b0, wr_sext = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] trap_psw_in = '0;
    logic [15:0] trap_psw_out;

    int total = 0;
    int bad   = 0;

    logic [15:0] m_low [2][6];
    logic [15:0] m_sp  [4];
    logic [15:0] m_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    rf_banked uut (
        .clk(clk), .rst_n(rst_n), .psw(psw),
        .rd_num(rd_num), .rd_prev(rd_prev), .rd_byte(rd_byte), .rd_data(rd_data),
        .wr_en(wr_en), .wr_num(wr_num), .wr_prev(wr_prev), .wr_sext(wr_sext),
        .wr_data(wr_data), .trap_psw_in(trap_psw_in), .trap_psw_out(trap_psw_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%04h expected=%04h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [2:0] n, input logic pv,
                                             input logic by, input logic [15:0] st);
        logic [15:0] v;
        if (n == 3'd7)      v = m_pc;
        else if (n == 3'd6) v = pv ? m_sp[st[13:12]] : m_sp[st[15:14]];
        else                v = m_low[st[11]][n];
        return by ? {8'h00, v[7:0]} : v;
    endfunction

    function automatic logic [15:0] exp_trap(input logic [15:0] st, input logic [15:0] vp);
        return {vp[15:14], st[15:14], vp[11:0]};
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 6; i++) m_low[s][i] = '0;
        for (int m = 0; m < 4; m++) m_sp[m] = '0;
        m_pc = '0;
    endtask

    task automatic model_write();
        logic [15:0] v;
        v = wr_sext ? {{8{wr_data[7]}}, wr_data[7:0]} : wr_data;
        if (wr_num == 3'd7)      m_pc = v;
        else if (wr_num == 3'd6) begin
            if (wr_prev) m_sp[psw[13:12]] = v; else m_sp[psw[15:14]] = v;
        end
        else m_low[psw[11]][wr_num] = v;
    endtask

    // One cycle: drive at the falling edge, check before the rising edge, commit after it.
    task automatic step(input string req, input logic [15:0] st, input logic [2:0] rn,
                        input logic rp, input logic rb, input logic we, input logic [2:0] wn,
                        input logic wp, input logic ws, input logic [15:0] wd,
                        input logic [15:0] tv);
        @(negedge clk);
        psw = st; rd_num = rn; rd_prev = rp; rd_byte = rb;
        wr_en = we; wr_num = wn; wr_prev = wp; wr_sext = ws; wr_data = wd;
        trap_psw_in = tv;
        #1;
        check(req, rd_data, exp_read(rn, rp, rb, st));
        check("R6", trap_psw_out, exp_trap(st, tv));
        @(posedge clk);
        if (we) model_write();
        #1;
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        model_clear();
        rst_n = 1'b0;
        // write attempt during reset must be ignored (R8)
        wr_en = 1'b1; wr_num = 3'd7; wr_data = 16'hBEEF;
        repeat (3) @(posedge clk);
        #1;
        wr_en = 1'b0;
        rst_n = 1'b1;

        // R8: every register and stack copy reads zero after reset
        for (int n = 0; n < 8; n++)
            step("R8", 16'h0800, 3'(n), 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        for (int m = 0; m < 4; m++)
            step("R8", 16'(m) << 14, 3'd6, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);

        // R1: same number in both sets holds different values
        step("R1", 16'h0000, 3'd2, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 16'h1111, 16'h0);
        step("R1", 16'h0800, 3'd2, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 16'h2222, 16'h0);
        step("R1", 16'h0000, 3'd2, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step("R1", 16'h0800, 3'd2, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);

        // R2, R3: current mode 3, previous mode 1
        step("R2", 16'hC000, 3'd6, 1'b0, 1'b0, 1'b1, 3'd6, 1'b0, 1'b0, 16'hAAAA, 16'h0);
        step("R3", 16'hD000, 3'd6, 1'b1, 1'b0, 1'b1, 3'd6, 1'b1, 1'b0, 16'h5555, 16'h0);
        step("R2", 16'hD000, 3'd6, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step("R3", 16'h1000, 3'd6, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step("R3", 16'h3000, 3'd6, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);

        // R4: PC shared across all status words
        step("R4", 16'h4800, 3'd7, 1'b0, 1'b0, 1'b1, 3'd7, 1'b1, 1'b0, 16'h1234, 16'h0);
        step("R4", 16'hF800, 3'd7, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step("R4", 16'h0000, 3'd7, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);

        // R9: same-cycle read sees old value, next cycle sees new
        step("R9", 16'h0000, 3'd4, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 16'h0F0F, 16'h0);
        step("R9", 16'h0000, 3'd4, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 16'hF0F0, 16'h0);
        step("R9", 16'h0000, 3'd4, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);

        // R7: sign-extending writes, negative and positive bytes
        step("R7", 16'h0000, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 16'h3480, 16'h0);
        step("R7", 16'h0000, 3'd0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1, 16'hFF7F, 16'h0);
        step("R7", 16'h0000, 3'd1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);

        // R5: byte read of a word with nonzero upper half
        step("R5", 16'h0000, 3'd7, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step("R5", 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);

        // R10: previous-mode flag on low registers is ignored
        step("R10", 16'h0800, 3'd3, 1'b1, 1'b0, 1'b1, 3'd3, 1'b1, 1'b0, 16'h7777, 16'h0);
        step("R10", 16'h0800, 3'd3, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step("R10", 16'h3800, 3'd3, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);

        // R6: trap word with distinct modes
        step("R6", 16'h8000, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h30E5);

        // Random mix over all requirements
        for (int k = 0; k < 2000; k++) begin
            step("R1-mix", 16'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                 16'($urandom), 16'($urandom));
        end

        finish_run();
    end
endmodule